// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Timed Strobes

This block connects a synchronous request/wait bus master to an external asynchronous static RAM. The master presents an address with a read or write request. The controller holds the request off with a wait signal only when it cannot take it yet. Once it takes an access, the controller drives the RAM pins from its own registers, so the master can move on at once. A write needs nothing more from the master. A read returns its data later, with a one-cycle valid pulse.

Access lengths for reads and writes are separate parameters counted in whole clock cycles. The active-low write strobe comes from a register clocked on the falling clock edge. It therefore goes low half a cycle after the address settles. It goes high again half a cycle before the address is allowed to move, so the address is steady across the whole low phase of the strobe. The data bus is split into an output word, an output enable and an input word. The controller releases the bus for at least one full cycle before any read turns the RAM outputs on. A read that directly follows a write therefore costs one extra cycle. Write-after-write, read-after-read and write-after-read can follow each other without a gap.

Top module: `asram_ctl`

## Requirements
- R1: While reset is held, and until the first access, chip enable, output enable and write strobe (all active low) are high, the data output enable is low, and wait and read-valid are low.
- R2: A read is taken at the rising edge where the request is present and wait is low. On that edge the address is registered and chip enable and output enable go low. They stay low for RD_CYCLES cycles. Data is sampled on the edge that ends the last of those cycles, and read-valid is high for exactly the following cycle, RD_CYCLES cycles after the accepting edge.
- R3: The last captured read data stays on the read data port after the valid pulse, unchanged by later writes, until the next read completes.
- R4: A write presented to an idle controller is taken without wait. For WR_CYCLES cycles from the accepting edge the write data is driven with the data output enable high, while output enable stays high.
- R5: The write strobe changes only on falling clock edges. It goes low on the falling edge inside the first write cycle and returns high on the falling edge inside the last write cycle, so it is low for WR_CYCLES-1 cycles.
- R6: While the write strobe is low, the address does not change and chip enable is low. The word driven on the data outputs is stored at the address when the strobe rises.
- R7: A request that arrives while an access runs is held with wait. Write-after-write and write-after-read are taken on the last cycle of the running access. Read-after-read is also taken then (stall of WR_CYCLES-1 or RD_CYCLES-1 cycles).
- R8: The data output enable and the RAM output enable are never active together. A read that follows a write is taken one cycle after the write ends (stall of WR_CYCLES cycles), so the data output enable has been low for a full cycle when output enable falls.
- R9: If read and write are requested in the same cycle, the write is performed and the read is dropped with no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge for control, falling edge for the write strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the request |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | DATA_W | Write data |
| bus_wait | output | 1 | Request cannot be taken this cycle |
| bus_rdata | output | DATA_W | Held read data |
| bus_rvalid | output | 1 | One-cycle pulse when new read data arrives |
| mem_addr | output | ADDR_W | Registered RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data read back from the RAM |

## Verification
The hardest case to reach from the ports is a new request landing in exactly the last cycle of a running access. That is the only cycle in which the controller chooses between back-to-back issue and the turnaround gap. The stimulus table therefore issues every access at the first moment the bench is able to. It mixes all four orderings of reads and writes, so each request is presented while the previous one is still running. The stall counts are then compared with the values expected for each ordering. A behavioural RAM in the bench stores on the rising strobe and returns a junk word whenever it is not enabled, so a capture on the wrong edge shows up as wrong data.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   function automatic int larger_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int count_width(input int top_value);
      return (top_value > 1) ? $clog2(top_value) : 1;
   endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int RD_CYCLES = 3,
   parameter int WR_CYCLES = 2,
   parameter int CNT_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_rd,
   input  logic             req_wr,
   output op_e              take,
   output logic             busy,
   output logic             cur_wr,
   output logic [CNT_W-1:0] cnt,
   output logic             ending,
   output logic             rd_done,
   output logic             bus_wait
);

   localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYCLES - 1);
   localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYCLES - 1);

   logic wr_ok;
   logic rd_ok;

   always_comb begin
      ending  = busy && (cnt == '0);
      rd_done = ending && !cur_wr;
      wr_ok   = !busy || ending;
      rd_ok   = !busy || (ending && !cur_wr);
      take    = OP_NONE;
      if (req_wr && wr_ok)
         take = OP_WRITE;
      else if (req_rd && !req_wr && rd_ok)
         take = OP_READ;
      bus_wait = (req_rd || req_wr) && (take == OP_NONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cur_wr <= 1'b0;
         cnt    <= '0;
      end else if (take != OP_NONE) begin
         busy   <= 1'b1;
         cur_wr <= (take == OP_WRITE);
         cnt    <= (take == OP_WRITE) ? WR_LOAD : RD_LOAD;
      end else if (ending) begin
         busy   <= 1'b0;
      end else if (busy) begin
         cnt    <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/asram_pins.sv
module asram_pins
   import asram_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               take,
   input  logic              ending,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_ce_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_dq_out <= '0;
         mem_dq_oe  <= 1'b0;
      end else if (take == OP_WRITE) begin
         mem_addr   <= bus_addr;
         mem_ce_n   <= 1'b0;
         mem_oe_n   <= 1'b1;
         mem_dq_out <= bus_wdata;
         mem_dq_oe  <= 1'b1;
      end else if (take == OP_READ) begin
         mem_addr   <= bus_addr;
         mem_ce_n   <= 1'b0;
         mem_oe_n   <= 1'b0;
         mem_dq_oe  <= 1'b0;
      end else if (ending) begin
         mem_ce_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_dq_oe  <= 1'b0;
      end
   end

endmodule

// File: rtl/asram_wstrobe.sv
module asram_wstrobe #(
   parameter int CNT_W    = 2,
   parameter bit NEG_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             cur_wr,
   input  logic [CNT_W-1:0] cnt,
   output logic             we_n
);

   generate
      if (NEG_EDGE) begin : g_fall
         // sampled mid-cycle: low from the first write cycle to the last
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)
               we_n <= 1'b1;
            else
               we_n <= !(busy && cur_wr && (cnt != '0));
         end
      end else begin : g_rise
         // whole-cycle strobe, one cycle of margin at each end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               we_n <= 1'b1;
            else
               we_n <= !(busy && cur_wr && (cnt > CNT_W'(1)));
         end
      end
   endgenerate

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_done,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd_done;
         if (rd_done)
            rdata <= dq_in;
      end
   end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
   import asram_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int RD_CYCLES   = 3,
   parameter int WR_CYCLES   = 2,
   parameter bit WE_NEG_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_wait,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int MAX_CYC = larger_of(RD_CYCLES, WR_CYCLES);
   localparam int CNT_W   = count_width(MAX_CYC);
   localparam int MIN_WR  = WE_NEG_EDGE ? 2 : 3;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_ctl: widths must be positive");
      end
      if (RD_CYCLES < 1) begin : g_bad_rd
         $error("asram_ctl: RD_CYCLES must be at least 1");
      end
      if (WR_CYCLES < MIN_WR) begin : g_bad_wr
         $error("asram_ctl: WR_CYCLES too short for the chosen strobe variant");
      end
   endgenerate

   op_e              take;
   logic             busy;
   logic             cur_wr;
   logic [CNT_W-1:0] cnt;
   logic             ending;
   logic             rd_done;

   asram_seq #(
      .RD_CYCLES (RD_CYCLES),
      .WR_CYCLES (WR_CYCLES),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_rd   (bus_rd),
      .req_wr   (bus_wr),
      .take     (take),
      .busy     (busy),
      .cur_wr   (cur_wr),
      .cnt      (cnt),
      .ending   (ending),
      .rd_done  (rd_done),
      .bus_wait (bus_wait)
   );

   asram_pins #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .ending     (ending),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .mem_addr   (mem_addr),
      .mem_ce_n   (mem_ce_n),
      .mem_oe_n   (mem_oe_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe)
   );

   asram_wstrobe #(
      .CNT_W    (CNT_W),
      .NEG_EDGE (WE_NEG_EDGE)
   ) u_wstrobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy   (busy),
      .cur_wr (cur_wr),
      .cnt    (cnt),
      .we_n   (mem_we_n)
   );

   asram_rdcap #(
      .DATA_W (DATA_W)
   ) u_rdcap (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_done (rd_done),
      .dq_in   (mem_dq_in),
      .rdata   (bus_rdata),
      .rvalid  (bus_rvalid)
   );

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
   parameter int ADDR_W    = 16,
   parameter int RD_CYCLES = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              bus_wait,
   input logic              bus_rvalid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe
);

   AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (RD_CYCLES > 1) && bus_rvalid |=> !bus_rvalid);                        // R2
   AST_RVALID_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rvalid) |-> $past(!mem_oe_n && !mem_ce_n));                   // R2
   AST_IDLE_WRITE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n && bus_wr |-> !bus_wait);                                       // R4
   AST_WE_INSIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));                     // R6
   AST_ADDR_HELD_UNDER_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n && $past(!mem_we_n) |-> $stable(mem_addr));                    // R6
   AST_WAIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wait |-> (bus_rd || bus_wr));                                        // R7
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n));                                              // R8
   AST_BUS_FREE_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> $past(!mem_dq_oe));                                  // R8

endmodule

bind asram_ctl asram_ctl_chk #(
   .ADDR_W    (ADDR_W),
   .RD_CYCLES (RD_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr),
   .bus_wait   (bus_wait),
   .bus_rvalid (bus_rvalid),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/asram_ctl_tb.sv
module asram_ctl_tb;

   localparam int AW  = 8;
   localparam int DW  = 16;
   localparam int RDC = 3;
   localparam int WRC = 2;
   localparam logic [DW-1:0] JUNK = 16'h5A5A;

   typedef struct packed {
      logic          wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VT [NV] = '{
      '{1'b1, 8'h10, 16'hA1A1},
      '{1'b1, 8'h11, 16'hB2B2},
      '{1'b0, 8'h10, 16'h0000},
      '{1'b0, 8'h11, 16'h0000},
      '{1'b1, 8'h10, 16'hC3C3},
      '{1'b0, 8'h10, 16'h0000},
      '{1'b0, 8'h20, 16'h0000},
      '{1'b1, 8'h20, 16'h0F0F},
      '{1'b1, 8'h21, 16'h7777},
      '{1'b0, 8'h21, 16'h0000},
      '{1'b0, 8'h20, 16'h0000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_wait;
   logic [DW-1:0] bus_rdata;
   logic          bus_rvalid;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n;
   logic          mem_oe_n;
   logic          mem_we_n;
   logic [DW-1:0] mem_dq_out;
   logic          mem_dq_oe;
   logic [DW-1:0] mem_dq_in;

   always #5 clk = ~clk;

   asram_ctl #(
      .ADDR_W    (AW),
      .DATA_W    (DW),
      .RD_CYCLES (RDC),
      .WR_CYCLES (WRC)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_wait   (bus_wait),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .mem_addr   (mem_addr),
      .mem_ce_n   (mem_ce_n),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe),
      .mem_dq_in  (mem_dq_in)
   );

   // behavioural RAM and its shadow in the bench
   logic [DW-1:0] sram   [0:255];
   logic [DW-1:0] shadow [0:255];
   assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? sram[mem_addr] : JUNK;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // read return monitor
   int            rv_cyc [$];
   logic [DW-1:0] rv_dat [$];
   int            ex_cyc [$];
   logic [DW-1:0] ex_dat [$];
   logic          dq_mid = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_rvalid) begin
            rv_cyc.push_back(cyc);
            rv_dat.push_back(bus_rdata);
         end
         if (mem_dq_oe && !mem_oe_n)
            chk("R8 contention", 32'd1, 32'd0);
      end
      dq_mid = mem_dq_oe;
   end

   always @(negedge mem_oe_n) begin
      if (rst_n) chk("R8 bus released before read", {30'd0, dq_mid, mem_dq_oe}, 32'd0);
   end

   // write strobe observers
   time           we_fall_t = 0;
   logic [AW-1:0] we_addr = '0;

   always @(negedge mem_we_n) begin
      if (rst_n) begin
         chk("R5 strobe falls on falling clock edge", {31'd0, clk}, 32'd0);
         we_fall_t = $time;
         we_addr   = mem_addr;
      end
   end

   always @(posedge mem_we_n) begin
      if (rst_n) begin
         chk("R5 strobe rises on falling clock edge", {31'd0, clk}, 32'd0);
         chk("R5 strobe low width", 32'($time - we_fall_t), 32'((WRC - 1) * 10));
         chk("R6 address at strobe rise", {24'd0, mem_addr}, {24'd0, we_addr});
         chk("R6 chip enable at strobe rise", {31'd0, mem_ce_n}, 32'd0);
         chk("R4 data driven at strobe rise", {31'd0, mem_dq_oe}, 32'd1);
         sram[mem_addr] = mem_dq_out;
      end
   end

   always @(mem_addr) begin
      if (rst_n && mem_we_n === 1'b0) chk("R6 address moved under strobe", 32'd1, 32'd0);
   end

   int acc_cyc = 0;

   // called at posedge+2; returns at posedge+2 of the accepting edge
   task automatic issue(input bit wr, input bit rd, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output int stalls);
      logic w;
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = wr;
      bus_rd    = rd;
      stalls    = 0;
      forever begin
         #6;
         w = bus_wait;
         @(posedge clk);
         #2;
         if (!w) break;
         stalls++;
      end
      acc_cyc = cyc;
      bus_wr  = 1'b0;
      bus_rd  = 1'b0;
      if (wr) shadow[a] = d;
      if (rd && !wr) begin
         ex_cyc.push_back(acc_cyc + RDC);
         ex_dat.push_back(shadow[a]);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic drain_and_compare(input string req);
      chk({req, " read count"}, 32'(rv_cyc.size()), 32'(ex_cyc.size()));
      while (rv_cyc.size() > 0 && ex_cyc.size() > 0) begin
         chk({req, " read timing"}, 32'(rv_cyc.pop_front()), 32'(ex_cyc.pop_front()));
         chk({req, " read data"}, {16'd0, rv_dat.pop_front()}, {16'd0, ex_dat.pop_front()});
      end
      rv_cyc.delete(); rv_dat.delete(); ex_cyc.delete(); ex_dat.delete();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin : main
      int st;
      int exp_st;
      int prev;
      int lows;
      for (int i = 0; i < 256; i++) begin
         sram[i]   = DW'(i * 257) ^ 16'h1234;
         shadow[i] = DW'(i * 257) ^ 16'h1234;
      end

      // R1: reset state
      #12;
      chk("R1 ce_n in reset", {31'd0, mem_ce_n}, 32'd1);
      chk("R1 oe_n in reset", {31'd0, mem_oe_n}, 32'd1);
      chk("R1 we_n in reset", {31'd0, mem_we_n}, 32'd1);
      chk("R1 dq_oe/wait/rvalid in reset", {29'd0, mem_dq_oe, bus_wait, bus_rvalid}, 32'd0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      idle(3);
      chk("R1 idle after reset", {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 32'b1110);

      // table of back-to-back accesses; R7 and R8 stall counts
      prev = -1;
      for (int i = 0; i < NV; i++) begin
         issue(VT[i].wr, !VT[i].wr, VT[i].a, VT[i].d, st);
         if (prev < 0)          exp_st = 0;
         else if (prev == 1)    exp_st = VT[i].wr ? WRC - 1 : WRC;
         else                   exp_st = RDC - 1;
         if (prev == 1 && !VT[i].wr)
            chk("R8 read after write stall", 32'(st), 32'(exp_st));
         else
            chk("R7 stall count", 32'(st), 32'(exp_st));
         prev = VT[i].wr ? 1 : 0;
      end
      idle(8);
      drain_and_compare("R2");

      // R3: read data held after its pulse, through a write
      chk("R3 rdata held", {16'd0, bus_rdata}, {16'd0, shadow[8'h20]});
      issue(1'b1, 1'b0, 8'h40, 16'h4444, st);
      chk("R4 write from idle not stalled", 32'(st), 32'd0);
      chk("R4 write pins", {13'd0, mem_addr, mem_oe_n, mem_dq_oe, mem_ce_n},
          {13'd0, 8'h40, 1'b1, 1'b1, 1'b0});
      chk("R4 write data", {16'd0, mem_dq_out}, 32'h4444);
      idle(1);
      chk("R4 data held second cycle", {30'd0, mem_dq_oe, mem_oe_n}, 32'b11);
      idle(4);
      chk("R3 rdata unchanged after write", {16'd0, bus_rdata}, {16'd0, shadow[8'h20]});
      chk("R3 no stray valid", 32'(rv_cyc.size()), 32'd0);

      // R2: read from idle, count output-enable cycles and address
      issue(1'b0, 1'b1, 8'h40, 16'h0, st);
      chk("R2 read address registered", {24'd0, mem_addr}, 32'h40);
      lows = 0;
      for (int k = 0; k < RDC + 3; k++) begin
         if (!mem_oe_n && !mem_ce_n) lows++;
         idle(1);
      end
      chk("R2 output enable length", 32'(lows), 32'(RDC));
      idle(2);
      drain_and_compare("R2 idle read");
      chk("R6 written word stored", {16'd0, sram[8'h40]}, 32'h4444);

      // R9: simultaneous read and write
      issue(1'b1, 1'b1, 8'h30, 16'hBEEF, st);
      idle(8);
      chk("R9 no valid for dropped read", 32'(rv_cyc.size()), 32'd0);
      rv_cyc.delete(); rv_dat.delete();
      issue(1'b0, 1'b1, 8'h30, 16'h0, st);
      idle(8);
      drain_and_compare("R9 write taken");

      summary();
      $finish;
   end

endmodule